// File: doc/BRIEF.md
# External Bus Chip-Select Timing Generator

This block runs one chip select of a slow parallel memory bus of the NOR-flash kind. A request arrives with an address, a read/write flag and write data. The block first tests the address against a select window: the window starts at a programmable multiple of 8 MB, spans a power-of-two number of those steps, and must start on a boundary that matches its own size. A request that fails this test never touches the bus. It is answered with an error.

An accepted request becomes one or two bus beats. In each beat, chip select stays low while one strobe is low and then high. The strobe is output-enable for a read and write-enable for a write. All durations are counted in bus clock cycles and come from programmed fields. A strobe can end after a fixed count or when an external acknowledge arrives. That acknowledge passes through a two-flop synchronizer, and its synchronized level is also available as a live status output. A 16-bit device takes one beat. An 8-bit device takes two beats on the low byte lane: the low byte goes first at the request address, then the high byte at the next address.

Top module: `xbus_cs_timing`

## Requirements
- R1: After reset, busCsN, busOeN and busWeN are 1, reqReady is 1 and accDone is 0.
- R2: A request is rejected when the offset is misaligned or the address lies outside the window. The offset is misaligned when any of its low cfgSizeLog bits is set. The address lies outside the window when the address bits above bit 22, with their low cfgSizeLog bits ignored, differ from cfgOffset with the same bits ignored. On rejection busCsN stays 1, and accDone and accErr are 1 in the cycle after acceptance.
- R3: With cfgUseAck=0, a read beat holds busOeN low for cfgWait cycles.
- R4: With cfgUseAck=0, a write beat holds busWeN low for cfgStrobeLo cycles. busDataOe is 1 and the write data is driven throughout.
- R5: After each strobe low phase, the strobe stays high with busCsN still low for cfgStrobeHi cycles.
- R6: With cfgUseAck=1, the low phase ends on the first clock edge at which the two-flop-synchronized acknowledge is 1. If busAckIn rises during the first strobe cycle, the low phase lasts 3 cycles.
- R7: ackLive equals busAckIn delayed by two clock edges.
- R8: With cfgWide=0, an access takes two beats on lane [7:0]. Beat 0 uses the request address and data bits [7:0]. Beat 1 uses address+1 and data bits [15:8]. rdData returns the beat 0 byte in [7:0] and the beat 1 byte in [15:8].
- R9: With cfgWide=1, an access takes one beat at the request address with all 16 data bits, and rdData is the full busDataIn.
- R10: All configuration inputs are captured when a request is accepted. Changing them during an access has no effect on that access.
- R11: accDone is a one-cycle pulse that follows the last recovery cycle. reqReady is 1 only when idle, so requests presented during an access are ignored.
- R12: A value of zero in cfgWait, cfgStrobeLo or cfgStrobeHi gives one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rstN | input | 1 | asynchronous active-low reset |
| cfgStrobeHi | input | 4 | strobe high (recovery) cycles |
| cfgStrobeLo | input | 4 | write strobe low cycles |
| cfgWait | input | 5 | read strobe low cycles (fixed mode) |
| cfgUseAck | input | 1 | 1: low phase ends on acknowledge |
| cfgWide | input | 1 | 1: 16-bit device, 0: 8-bit device |
| cfgOffset | input | 4 | window start in 8 MB steps |
| cfgSizeLog | input | 2 | window size is 2^cfgSizeLog steps |
| reqValid | input | 1 | request present |
| reqAddr | input | 27 | request byte address |
| reqWrite | input | 1 | 1: write, 0: read |
| reqWrData | input | 16 | write data |
| reqReady | output | 1 | block idle, request accepted on this edge |
| accDone | output | 1 | access finished pulse |
| accErr | output | 1 | with accDone: request rejected |
| rdData | output | 16 | read result, valid with accDone |
| busCsN | output | 1 | chip select, active low |
| busOeN | output | 1 | output enable, active low |
| busWeN | output | 1 | write enable, active low |
| busAddr | output | 27 | bus address |
| busDataOut | output | 16 | bus write data |
| busDataOe | output | 1 | drive enable for busDataOut |
| busDataIn | input | 16 | bus read data |
| busAckIn | input | 1 | asynchronous acknowledge |
| ackLive | output | 1 | synchronized acknowledge level |

## Verification
Outputs are decoded from the state register, so the strobe for beat 0 goes low in the first cycle after the accepting edge. A fixed access then reports accDone in cycle beats*(low+high)+1, and a rejected request reports it in cycle 1. The acknowledge reaches the control after two synchronizer edges. An acknowledge raised in the first strobe cycle therefore ends the low phase after exactly three cycles, and ackLive follows busAckIn two edges late. The bench samples at the falling edge and counts cycles from the accepting edge. Each strobe and recovery length, each beat address and lane, and the done cycle are compared against those counts.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RECOVER = 2'd2,
    ST_FINISH  = 2'd3
  } csState_e;

  typedef struct packed {
    logic latchReq;
    logic loadRecover;
    logic decCount;
    logic captureRd;
    logic nextBeat;
  } dpCtl_t;

endpackage

// File: rtl/xbus_ack_sync.sv
module xbus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/xbus_cs_datapath.sv
module xbus_cs_datapath
  import cs_timing_pkg::*;
#(
  parameter int STEP_BITS = 23,
  parameter int OFFS_W    = 4,
  parameter int SIZE_W    = 2,
  parameter int HI_W      = 4,
  parameter int LO_W      = 4,
  parameter int WAIT_W    = 5,
  parameter int DATA_W    = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtl_t                         ctl,
  input  logic [HI_W-1:0]                cfgStrobeHi,
  input  logic [LO_W-1:0]                cfgStrobeLo,
  input  logic [WAIT_W-1:0]              cfgWait,
  input  logic                           cfgUseAck,
  input  logic                           cfgWide,
  input  logic [OFFS_W-1:0]              cfgOffset,
  input  logic [SIZE_W-1:0]              cfgSizeLog,
  input  logic [STEP_BITS+OFFS_W-1:0]    reqAddr,
  input  logic                           reqWrite,
  input  logic [DATA_W-1:0]              reqWrData,
  input  logic [DATA_W-1:0]              busDataIn,
  output logic                           addrOk,
  output logic                           cntZero,
  output logic                           lastBeat,
  output logic                           writeL,
  output logic                           useAckL,
  output logic [STEP_BITS+OFFS_W-1:0]    busAddr,
  output logic [DATA_W-1:0]              busDataOut,
  output logic [DATA_W-1:0]              rdData
);

  localparam int ADDR_W = STEP_BITS + OFFS_W;
  localparam int LANE_W = DATA_W / 2;
  localparam int CNT_W  = (WAIT_W > LO_W) ? ((WAIT_W > HI_W) ? WAIT_W : HI_W)
                                          : ((LO_W > HI_W) ? LO_W : HI_W);

  function automatic logic [CNT_W-1:0] lenMinusOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // window test on live inputs
  logic [OFFS_W-1:0] reqStep;
  logic [OFFS_W-1:0] sizeMask;
  logic              offsAligned;
  logic              inWindow;

  assign reqStep     = reqAddr[ADDR_W-1 -: OFFS_W];
  assign sizeMask    = (OFFS_W'(1) << cfgSizeLog) - OFFS_W'(1);
  assign offsAligned = (cfgOffset & sizeMask) == '0;
  assign inWindow    = ((reqStep ^ cfgOffset) & ~sizeMask) == '0;
  assign addrOk      = offsAligned && inWindow;

  // captured request and profile
  logic [ADDR_W-1:0] addrL;
  logic [DATA_W-1:0] dataL;
  logic              wideL;
  logic [HI_W-1:0]   hiL;
  logic [LO_W-1:0]   loL;
  logic [WAIT_W-1:0] waitL;
  logic              beat;
  logic [CNT_W-1:0]  cnt;

  logic [CNT_W-1:0]  liveLowLen;
  logic [CNT_W-1:0]  heldLowLen;
  logic [CNT_W-1:0]  heldHighLen;

  assign liveLowLen  = lenMinusOne(reqWrite ? CNT_W'(cfgStrobeLo) : CNT_W'(cfgWait));
  assign heldLowLen  = lenMinusOne(writeL ? CNT_W'(loL) : CNT_W'(waitL));
  assign heldHighLen = lenMinusOne(CNT_W'(hiL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrL   <= '0;
      dataL   <= '0;
      writeL  <= 1'b0;
      wideL   <= 1'b1;
      useAckL <= 1'b0;
      hiL     <= '0;
      loL     <= '0;
      waitL   <= '0;
    end else if (ctl.latchReq) begin
      addrL   <= reqAddr;
      dataL   <= reqWrData;
      writeL  <= reqWrite;
      wideL   <= cfgWide;
      useAckL <= cfgUseAck;
      hiL     <= cfgStrobeHi;
      loL     <= cfgStrobeLo;
      waitL   <= cfgWait;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              beat <= 1'b0;
    else if (ctl.latchReq)  beat <= 1'b0;
    else if (ctl.nextBeat)  beat <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (ctl.latchReq)     cnt <= liveLowLen;
    else if (ctl.nextBeat)     cnt <= heldLowLen;
    else if (ctl.loadRecover)  cnt <= heldHighLen;
    else if (ctl.decCount)     cnt <= cnt - 1'b1;
  end

  assign cntZero  = (cnt == '0);
  assign lastBeat = wideL || beat;

  // bus address and write lane
  assign busAddr = wideL ? addrL : addrL + ADDR_W'(beat);

  always_comb begin
    if (wideL)     busDataOut = dataL;
    else if (beat) busDataOut = {{LANE_W{1'b0}}, dataL[DATA_W-1:LANE_W]};
    else           busDataOut = {{LANE_W{1'b0}}, dataL[LANE_W-1:0]};
  end

  // read assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.captureRd) begin
      if (wideL)     rdData                  <= busDataIn;
      else if (beat) rdData[DATA_W-1:LANE_W] <= busDataIn[LANE_W-1:0];
      else           rdData[LANE_W-1:0]      <= busDataIn[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/xbus_cs_control.sv
module xbus_cs_control
  import cs_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   addrOk,
  input  logic   cntZero,
  input  logic   lastBeat,
  input  logic   writeL,
  input  logic   useAckL,
  input  logic   syncAck,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   accDone,
  output logic   accErr,
  output logic   busCsN,
  output logic   busOeN,
  output logic   busWeN,
  output logic   busDataOe
);

  csState_e state;
  csState_e nextState;
  logic     errL;
  logic     endStrobe;

  assign endStrobe = useAckL ? syncAck : cntZero;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nextState    = addrOk ? ST_STROBE : ST_FINISH;
        end
      end
      ST_STROBE: begin
        if (endStrobe) begin
          ctl.loadRecover = 1'b1;
          ctl.captureRd   = !writeL;
          nextState       = ST_RECOVER;
        end else begin
          ctl.decCount = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cntZero) begin
          if (lastBeat) begin
            nextState = ST_FINISH;
          end else begin
            ctl.nextBeat = 1'b1;
            nextState    = ST_STROBE;
          end
        end else begin
          ctl.decCount = 1'b1;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                errL <= 1'b0;
    else if (state == ST_IDLE && reqValid)    errL <= !addrOk;
  end

  assign reqReady  = (state == ST_IDLE);
  assign accDone   = (state == ST_FINISH);
  assign accErr    = (state == ST_FINISH) && errL;
  assign busCsN    = !(state == ST_STROBE || state == ST_RECOVER);
  assign busOeN    = !(state == ST_STROBE && !writeL);
  assign busWeN    = !(state == ST_STROBE && writeL);
  assign busDataOe = !busCsN && writeL;

endmodule

// File: rtl/xbus_cs_timing.sv
module xbus_cs_timing
  import cs_timing_pkg::*;
#(
  parameter int STEP_BITS  = 23,
  parameter int OFFS_W     = 4,
  parameter int SIZE_W     = 2,
  parameter int HI_W       = 4,
  parameter int LO_W       = 4,
  parameter int WAIT_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ACK_STAGES = 2,
  localparam int ADDR_W    = STEP_BITS + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HI_W-1:0]   cfgStrobeHi,
  input  logic [LO_W-1:0]   cfgStrobeLo,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgUseAck,
  input  logic              cfgWide,
  input  logic [OFFS_W-1:0] cfgOffset,
  input  logic [SIZE_W-1:0] cfgSizeLog,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqReady,
  output logic              accDone,
  output logic              accErr,
  output logic [DATA_W-1:0] rdData,
  output logic              busCsN,
  output logic              busOeN,
  output logic              busWeN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busAckIn,
  output logic              ackLive
);

  dpCtl_t ctl;
  logic   addrOk;
  logic   cntZero;
  logic   lastBeat;
  logic   writeL;
  logic   useAckL;
  logic   syncAck;

  xbus_ack_sync #(.STAGES(ACK_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busAckIn),
    .syncOut (syncAck)
  );

  xbus_cs_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .addrOk    (addrOk),
    .cntZero   (cntZero),
    .lastBeat  (lastBeat),
    .writeL    (writeL),
    .useAckL   (useAckL),
    .syncAck   (syncAck),
    .ctl       (ctl),
    .reqReady  (reqReady),
    .accDone   (accDone),
    .accErr    (accErr),
    .busCsN    (busCsN),
    .busOeN    (busOeN),
    .busWeN    (busWeN),
    .busDataOe (busDataOe)
  );

  xbus_cs_datapath #(
    .STEP_BITS (STEP_BITS),
    .OFFS_W    (OFFS_W),
    .SIZE_W    (SIZE_W),
    .HI_W      (HI_W),
    .LO_W      (LO_W),
    .WAIT_W    (WAIT_W),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgStrobeHi (cfgStrobeHi),
    .cfgStrobeLo (cfgStrobeLo),
    .cfgWait     (cfgWait),
    .cfgUseAck   (cfgUseAck),
    .cfgWide     (cfgWide),
    .cfgOffset   (cfgOffset),
    .cfgSizeLog  (cfgSizeLog),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqWrData   (reqWrData),
    .busDataIn   (busDataIn),
    .addrOk      (addrOk),
    .cntZero     (cntZero),
    .lastBeat    (lastBeat),
    .writeL      (writeL),
    .useAckL     (useAckL),
    .busAddr     (busAddr),
    .busDataOut  (busDataOut),
    .rdData      (rdData)
  );

  assign ackLive = syncAck;

endmodule

// File: rtl/xbus_cs_timing_chk.sv
module xbus_cs_timing_chk (
  input logic clk,
  input logic rstN,
  input logic busCsN,
  input logic busOeN,
  input logic busWeN,
  input logic busDataOe,
  input logic reqReady,
  input logic accDone,
  input logic accErr,
  input logic busAckIn,
  input logic ackLive
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R3 / R4: only one strobe at a time
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!busOeN && !busWeN));

  // R5: strobes only inside an asserted select
  a_r5_strobe_in_select: assert property (@(posedge clk) disable iff (!rstN)
    (!busOeN || !busWeN) |-> !busCsN);

  // R2: a rejected request never asserted the select
  a_r2_reject_no_select: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (busCsN && $past(busCsN)));

  // R11: done is a single pulse and returns to idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> (!accDone && reqReady));

  // R4: write data is only driven while selected
  a_r4_drive_in_select: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !busCsN);

  // R7: status is the input two edges late
  a_r7_ack_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (ackLive == $past(busAckIn, 2)));

endmodule

bind xbus_cs_timing xbus_cs_timing_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busCsN    (busCsN),
  .busOeN    (busOeN),
  .busWeN    (busWeN),
  .busDataOe (busDataOe),
  .reqReady  (reqReady),
  .accDone   (accDone),
  .accErr    (accErr),
  .busAckIn  (busAckIn),
  .ackLive   (ackLive)
);

// File: tb/xbus_cs_timing_tb.sv
`timescale 1ns/1ps
module xbus_cs_timing_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgStrobeHi = '0;
  logic [3:0]  cfgStrobeLo = '0;
  logic [4:0]  cfgWait = '0;
  logic        cfgUseAck = 1'b0;
  logic        cfgWide = 1'b1;
  logic [3:0]  cfgOffset = 4'd4;
  logic [1:0]  cfgSizeLog = 2'd1;
  logic        reqValid = 1'b0;
  logic [26:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWrData = '0;
  logic        reqReady, accDone, accErr;
  logic [15:0] rdData;
  logic        busCsN, busOeN, busWeN, busDataOe;
  logic [26:0] busAddr;
  logic [15:0] busDataOut;
  logic [15:0] busDataIn;
  logic        busAckIn = 1'b0;
  logic        ackLive;

  always #10 clk = ~clk;

  assign busDataIn = {busAddr[7:0] ^ 8'hA5, busAddr[7:0]};

  xbus_cs_timing u_dut (
    .clk(clk), .rstN(rstN),
    .cfgStrobeHi(cfgStrobeHi), .cfgStrobeLo(cfgStrobeLo), .cfgWait(cfgWait),
    .cfgUseAck(cfgUseAck), .cfgWide(cfgWide), .cfgOffset(cfgOffset),
    .cfgSizeLog(cfgSizeLog), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWrData(reqWrData), .reqReady(reqReady),
    .accDone(accDone), .accErr(accErr), .rdData(rdData), .busCsN(busCsN),
    .busOeN(busOeN), .busWeN(busWeN), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn),
    .busAckIn(busAckIn), .ackLive(ackLive)
  );

  int total = 0;
  int bad = 0;

  int          mBeats, mTotal;
  int          mS [2];
  int          mR [2];
  logic [26:0] mA [2];
  logic [15:0] mD [2];
  logic        mOe [2];
  logic        mErr;
  logic [15:0] mRd;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one access, monitored cycle by cycle from the accepting edge
  task automatic runAccess(input logic wr, input logic [26:0] addr,
                           input logic [15:0] wd, input bit driveAck,
                           input bit bogusBusy, input bit bumpCfg);
    int  bi;
    bit  prevStrobe;
    bit  strobe;
    mBeats = 0; mTotal = 0; mErr = 1'b0; mRd = '0;
    for (int i = 0; i < 2; i++) begin
      mS[i] = 0; mR[i] = 0; mA[i] = '0; mD[i] = '0; mOe[i] = 1'b0;
    end
    bi = -1; prevStrobe = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqWrData = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (bogusBusy) begin
      reqValid = 1'b1; reqAddr = {4'd4, 23'h0}; reqWrite = 1'b1;
    end
    for (int k = 1; k <= 300; k++) begin
      if (bumpCfg && k == 1) begin
        cfgStrobeLo = 4'd9; cfgStrobeHi = 4'd7;
      end
      strobe = !busOeN || !busWeN;
      if (strobe) begin
        if (!prevStrobe) begin
          bi++;
          if (bi < 2) begin
            mA[bi] = busAddr; mD[bi] = busDataOut; mOe[bi] = busDataOe;
          end
        end
        if (bi >= 0 && bi < 2) mS[bi]++;
        if (driveAck) busAckIn = 1'b1;
      end else if (!busCsN) begin
        if (bi >= 0 && bi < 2) mR[bi]++;
        if (driveAck) busAckIn = 1'b0;
      end
      prevStrobe = strobe;
      if (accDone) begin
        mTotal = k; mErr = accErr; mRd = rdData;
        reqValid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    busAckIn = 1'b0;
    mBeats = bi + 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input int hi, input int lo, input int wt,
                        input bit useAck, input bit wide);
    cfgStrobeHi = 4'(hi); cfgStrobeLo = 4'(lo); cfgWait = 5'(wt);
    cfgUseAck = useAck; cfgWide = wide;
    cfgOffset = 4'd4; cfgSizeLog = 2'd1;
  endtask

  task automatic t_reset();
    check(busCsN && busOeN && busWeN, "R1", "strobes idle", {busCsN, busOeN, busWeN}, 3'b111);
    check(reqReady == 1'b1, "R1", "ready", reqReady, 1);
    check(accDone == 1'b0, "R1", "done", accDone, 0);
  endtask

  task automatic t_wide_read();
    logic [26:0] a = {4'd5, 23'h01234};
    setCfg(2, 7, 3, 0, 1);
    runAccess(1'b0, a, 16'h0, 0, 0, 0);
    check(mBeats == 1, "R9", "beats", mBeats, 1);
    check(mS[0] == 3, "R3", "oe low cycles", mS[0], 3);
    check(mR[0] == 2, "R5", "recovery cycles", mR[0], 2);
    check(mA[0] == a, "R9", "address", mA[0], a);
    check(mTotal == 6, "R11", "done cycle", mTotal, 6);
    check(mRd == {a[7:0] ^ 8'hA5, a[7:0]} && !mErr, "R9", "read data",
          mRd, {a[7:0] ^ 8'hA5, a[7:0]});
  endtask

  task automatic t_wide_write();
    logic [26:0] a = {4'd4, 23'h00F00};
    setCfg(1, 4, 9, 0, 1);
    runAccess(1'b1, a, 16'hBEEF, 0, 0, 0);
    check(mS[0] == 4, "R4", "we low cycles", mS[0], 4);
    check(mR[0] == 1, "R5", "recovery cycles", mR[0], 1);
    check(mD[0] == 16'hBEEF && mOe[0], "R4", "write data", mD[0], 16'hBEEF);
    check(mTotal == 6, "R11", "done cycle", mTotal, 6);
  endtask

  task automatic t_narrow_write();
    logic [26:0] a = {4'd5, 23'h00010};
    setCfg(3, 2, 1, 0, 0);
    runAccess(1'b1, a, 16'h12AB, 0, 0, 0);
    check(mBeats == 2, "R8", "beats", mBeats, 2);
    check(mA[0] == a && mA[1] == a + 27'd1, "R8", "beat1 address", mA[1], a + 27'd1);
    check(mD[0] == 16'h00AB, "R8", "low byte first", mD[0], 16'h00AB);
    check(mD[1] == 16'h0012, "R8", "high byte second", mD[1], 16'h0012);
    check(mS[1] == 2 && mR[1] == 3, "R5", "beat1 timing", {mS[1], mR[1]}, {32'd2, 32'd3});
    check(mTotal == 11, "R11", "done cycle", mTotal, 11);
  endtask

  task automatic t_narrow_read();
    logic [26:0] a = {4'd4, 23'h000FE};
    logic [15:0] exp;
    setCfg(1, 1, 1, 0, 0);
    runAccess(1'b0, a, 16'h0, 0, 0, 0);
    exp = {8'hFF, 8'hFE};
    check(mRd == exp, "R8", "assembled read", mRd, exp);
    check(mTotal == 5, "R11", "done cycle", mTotal, 5);
  endtask

  task automatic t_zero_counts();
    setCfg(0, 0, 0, 0, 1);
    runAccess(1'b1, {4'd4, 23'h8}, 16'h5555, 0, 0, 0);
    check(mS[0] == 1 && mR[0] == 1, "R12", "write zero fields", {mS[0], mR[0]}, {32'd1, 32'd1});
    runAccess(1'b0, {4'd4, 23'h8}, 16'h0, 0, 0, 0);
    check(mS[0] == 1 && mTotal == 3, "R12", "read zero wait", {mS[0], mTotal}, {32'd1, 32'd3});
  endtask

  task automatic t_ack_mode();
    setCfg(2, 1, 20, 1, 1);
    runAccess(1'b0, {4'd5, 23'h40}, 16'h0, 1, 0, 0);
    check(mS[0] == 3, "R6", "ack read low", mS[0], 3);
    check(mR[0] == 2, "R6", "ack read recovery", mR[0], 2);
    setCfg(4, 1, 1, 1, 0);
    runAccess(1'b1, {4'd5, 23'h40}, 16'hA1B2, 1, 0, 0);
    check(mBeats == 2 && mS[0] == 3 && mS[1] == 3, "R6", "ack narrow beats",
          {mS[0], mS[1]}, {32'd3, 32'd3});
  endtask

  task automatic t_ack_live();
    @(negedge clk); busAckIn = 1'b1;
    @(negedge clk);
    check(ackLive == 1'b0, "R7", "after one edge", ackLive, 0);
    @(negedge clk);
    check(ackLive == 1'b1, "R7", "after two edges", ackLive, 1);
    busAckIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check(ackLive == 1'b0, "R7", "falls two edges later", ackLive, 0);
  endtask

  task automatic t_reject();
    setCfg(2, 2, 2, 0, 1);
    runAccess(1'b1, {4'd6, 23'h0}, 16'h1, 0, 0, 0);
    check(mErr && mTotal == 1 && mBeats == 0, "R2", "outside window",
          {mErr, mTotal[7:0]}, {1'b1, 8'd1});
    cfgOffset = 4'd5;
    runAccess(1'b0, {4'd5, 23'h0}, 16'h0, 0, 0, 0);
    check(mErr && mTotal == 1 && mBeats == 0, "R2", "misaligned offset",
          {mErr, mTotal[7:0]}, {1'b1, 8'd1});
    cfgOffset = 4'd4;
    runAccess(1'b0, {4'd5, 23'h7FFFFE}, 16'h0, 0, 0, 0);
    check(!mErr && mBeats == 1, "R2", "upper step inside window", mErr, 0);
  endtask

  task automatic t_cfg_latched();
    setCfg(1, 2, 2, 0, 1);
    runAccess(1'b1, {4'd4, 23'h100}, 16'h7777, 0, 0, 1);
    check(mS[0] == 2 && mR[0] == 1, "R10", "profile held", {mS[0], mR[0]}, {32'd2, 32'd1});
  endtask

  task automatic t_busy_ignored();
    bit quiet = 1'b1;
    setCfg(2, 3, 3, 0, 1);
    runAccess(1'b0, {4'd4, 23'h200}, 16'h0, 0, 1, 0);
    check(mTotal == 6, "R11", "busy access length", mTotal, 6);
    for (int i = 0; i < 4; i++) begin
      if (!busCsN || !reqReady) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R11", "no access from busy request", quiet, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_read();
    t_wide_write();
    t_narrow_write();
    t_narrow_read();
    t_zero_counts();
    t_ack_mode();
    t_ack_live();
    t_reject();
    t_cfg_latched();
    t_busy_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule